// File: doc/BRIEF.md
# Register-Mapped Byte FIFO with Fill Status

This block holds up to 64 bytes between a 32-bit host register interface and a byte-wide serial datapath. The host sees two addresses. One is a control/status word that reports fill state and holds the almost-empty threshold and a flush command. The other is a data port that carries one byte in its low eight bits. The serial side uses a byte valid/ready handshake.

A build-time parameter selects the direction. In transmit mode the host writes bytes into the data port and the serializer drains them through the output handshake. In receive mode the serializer pushes bytes through the input handshake and the host reads them from the data port. Two sticky flags record lost bytes. Overflow is set when a byte arrives while the FIFO is full. Underflow is set when a byte is requested while the FIFO is empty. An almost-empty output lets a neighbouring block request a refill.

The host interface is single-cycle. `bus_rdata` is combinational from the current state, and a data-port read in receive mode removes the byte at the clock edge that ends the access. Address 0 selects the control/status word and address 1 selects the data port.

Top module: `byte_fifo_csr`

## Requirements
- R1: After reset the threshold and both sticky flags are 0, the FIFO is empty, and a read of the control/status word returns 0x00004000 (only the Empty bit, bit 14, set).
- R2: Bytes leave in the order they entered. In transmit mode `out_valid` is high exactly while at least one byte is stored, and `out_data` then shows the oldest byte. Bits 31..8 of a data-port write are ignored.
- R3: Status bit 14 is 1 exactly when 0 bytes are stored. Bit 13 is 1 exactly when 64 bytes are stored. Bits 5..0 give the stored count modulo 64, so they read 0 when the FIFO is full.
- R4: A byte offered while the FIFO is full is dropped, stored bytes are left unchanged, and the sticky overflow flag (status bit 15) is set.
- R5: Status bits 11..6 are a read/write threshold. `almost_empty` is 1 exactly when the stored count is at or below the threshold, so it is never 1 while the FIFO is full.
- R6: Writing 1 to status bit 12 empties the FIFO and clears both sticky flags in that write. The threshold field is still loaded by the same write, and bit 12 always reads back 0.
- R7: A byte request while the FIFO is empty removes nothing and sets the sticky underflow flag (status bit 16). In transmit mode the request is `out_ready` with `out_valid` low.
- R8: In receive mode `in_ready` is always 1 and each `in_valid` cycle offers one byte. A data-port read returns the oldest byte in bits 7..0, with bits 31..8 as 0, and removes that byte. A read while empty returns 0.
- R9: When a byte is added and one removed in the same cycle, the count does not change. When a flush and an incoming byte fall in the same cycle, the flush wins and the FIFO ends up empty.
- R10: A data-port read in transmit mode returns 0 and removes nothing. A data-port write in receive mode stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status word, 1 = data port |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for the addressed word |
| in_valid | input | 1 | Receive mode: serializer offers a byte |
| in_data | input | 8 | Receive mode: offered byte |
| in_ready | output | 1 | Receive mode: always 1; 0 in transmit mode |
| out_valid | output | 1 | Transmit mode: a byte is available |
| out_data | output | 8 | Transmit mode: oldest stored byte |
| out_ready | input | 1 | Transmit mode: serializer takes the byte |
| almost_empty | output | 1 | Count at or below the threshold |

## Verification
Two pairs of events can share one clock edge, and each pair is driven together on purpose. In transmit mode a host data-port write and a serializer take happen in the same cycle. The bench checks that the departing byte is the oldest one and that the level field is unchanged afterwards. In receive mode a control write with the flush bit set lands in the same cycle as an `in_valid` byte. The status must then read back as plain empty, which shows that the flush took precedence over the push.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;

    localparam int BUS_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int FIELD_W = 6;

    // bit positions of the control/status word that software decodes
    localparam int POS_UDF   = 16;
    localparam int POS_OVF   = 15;
    localparam int POS_EMPTY = 14;
    localparam int POS_FULL  = 13;
    localparam int POS_FLUSH = 12;
    localparam int POS_THR   = 6;

    typedef enum logic {
        ADDR_CSR  = 1'b0,
        ADDR_DATA = 1'b1
    } port_addr_e;

    typedef struct packed {
        logic               udf;
        logic               ovf;
        logic               empty;
        logic               full;
        logic               flush_rd;
        logic [FIELD_W-1:0] thr;
        logic [FIELD_W-1:0] lvl;
    } csr_view_t;

    localparam int VIEW_W = $bits(csr_view_t);

    function automatic logic [BUS_W-1:0] pack_csr(input csr_view_t v);
        return {{(BUS_W-VIEW_W){1'b0}}, v};
    endfunction

    function automatic logic [FIELD_W-1:0] field_thr(input logic [BUS_W-1:0] w);
        return w[POS_THR +: FIELD_W];
    endfunction

endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store
    import byte_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [BYTE_W-1:0] head_o,
    output logic [CW-1:0]     count_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              push_drop_o,
    output logic              pop_miss_o
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     cnt;
    logic              do_push;
    logic              do_pop;

    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));

    assign do_push     = push_i & ~full_o  & ~flush_i;
    assign do_pop      = pop_i  & ~empty_o & ~flush_i;
    assign push_drop_o = push_i &  full_o  & ~flush_i;
    assign pop_miss_o  = pop_i  &  empty_o & ~flush_i;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = cnt;

endmodule

// File: rtl/byte_fifo_regs.sv
module byte_fifo_regs
    import byte_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             push_drop_i,
    input  logic             pop_miss_i,
    input  logic [CW-1:0]    count_i,
    input  logic             empty_i,
    input  logic             full_i,
    output logic             flush_o,
    output logic             ovf_o,
    output logic             udf_o,
    output logic             ae_o,
    output logic [BUS_W-1:0] csr_rdata_o
);

    logic [FIELD_W-1:0] thr_q;
    logic               ovf_q;
    logic               udf_q;
    csr_view_t          view;

    // the flush command lives only for the write cycle, so it clears itself
    assign flush_o = csr_wr_i & wdata_i[POS_FLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (csr_wr_i) begin
            thr_q <= field_thr(wdata_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush_o) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (push_drop_i) begin
                ovf_q <= 1'b1;
            end
            if (pop_miss_i) begin
                udf_q <= 1'b1;
            end
        end
    end

    assign ae_o = (int'(count_i) <= int'(thr_q));

    always_comb begin
        view          = '0;
        view.udf      = udf_q;
        view.ovf      = ovf_q;
        view.empty    = empty_i;
        view.full     = full_i;
        view.flush_rd = 1'b0;
        view.thr      = thr_q;
        view.lvl      = FIELD_W'(count_i[AW-1:0]);
    end

    assign csr_rdata_o = pack_csr(view);
    assign ovf_o       = ovf_q;
    assign udf_o       = udf_q;

endmodule

// File: rtl/byte_fifo_csr.sv
module byte_fifo_csr
    import byte_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter bit IS_RX = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              almost_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic              csr_wr;
    logic              data_wr;
    logic              data_rd;
    logic              flush;
    logic              push;
    logic [BYTE_W-1:0] push_data;
    logic              pop;
    logic [BYTE_W-1:0] head;
    logic [CW-1:0]     count;
    logic              empty;
    logic              full;
    logic              push_drop;
    logic              pop_miss;
    logic              ovf;
    logic              udf;
    logic [BUS_W-1:0]  csr_rdata;
    logic [BUS_W-1:0]  data_rdata;

    assign csr_wr  = bus_sel &  bus_wr & (port_addr_e'(bus_addr) == ADDR_CSR);
    assign data_wr = bus_sel &  bus_wr & (port_addr_e'(bus_addr) == ADDR_DATA);
    assign data_rd = bus_sel & ~bus_wr & (port_addr_e'(bus_addr) == ADDR_DATA);

    always_comb begin
        if (IS_RX) begin
            push       = in_valid;
            push_data  = in_data;
            pop        = data_rd;
            in_ready   = 1'b1;
            out_valid  = 1'b0;
            out_data   = '0;
            data_rdata = empty ? '0 : {{(BUS_W-BYTE_W){1'b0}}, head};
        end else begin
            push       = data_wr;
            push_data  = bus_wdata[BYTE_W-1:0];
            pop        = out_ready;
            in_ready   = 1'b0;
            out_valid  = ~empty;
            out_data   = head;
            data_rdata = '0;
        end
    end

    byte_fifo_store #(.DEPTH(DEPTH)) store_i (
        .clk         (clk),
        .rst         (rst),
        .flush_i     (flush),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (pop),
        .head_o      (head),
        .count_o     (count),
        .empty_o     (empty),
        .full_o      (full),
        .push_drop_o (push_drop),
        .pop_miss_o  (pop_miss)
    );

    byte_fifo_regs #(.DEPTH(DEPTH)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .csr_wr_i    (csr_wr),
        .wdata_i     (bus_wdata),
        .push_drop_i (push_drop),
        .pop_miss_i  (pop_miss),
        .count_i     (count),
        .empty_i     (empty),
        .full_i      (full),
        .flush_o     (flush),
        .ovf_o       (ovf),
        .udf_o       (udf),
        .ae_o        (almost_empty),
        .csr_rdata_o (csr_rdata)
    );

    assign bus_rdata = (port_addr_e'(bus_addr) == ADDR_CSR) ? csr_rdata : data_rdata;

endmodule

// File: rtl/byte_fifo_csr_chk.sv
module byte_fifo_csr_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          empty,
    input logic          ovf,
    input logic          udf,
    input logic          ae
);

    // R3: the stored count never exceeds the capacity
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    // R3: full and empty never hold together
    a_r3_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R9: without a flush the count moves by at most one per cycle
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (count == $past(count) ||
                    int'(count) == int'($past(count)) + 1 ||
                    int'(count) + 1 == int'($past(count))));

    // R6: a flush leaves an empty FIFO with clean flags
    a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !ovf && !udf));

    // R4: overflow stays set until a flush
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !flush) |=> ovf);

    // R7: underflow stays set until a flush
    a_r7_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        (udf && !flush) |=> udf);

    // R5: a full FIFO is never almost empty
    a_r5_full_not_ae: assert property (@(posedge clk) disable iff (rst)
        full |-> !ae);

endmodule

bind byte_fifo_csr byte_fifo_csr_chk #(.DEPTH(DEPTH)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .count (count),
    .full  (full),
    .empty (empty),
    .ovf   (ovf),
    .udf   (udf),
    .ae    (almost_empty)
);

// File: tb/byte_fifo_csr_tb_top.sv
module byte_fifo_csr_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // transmit-mode instance
    logic        t_sel = 0, t_wr = 0, t_addr = 0, t_rdy = 0;
    logic [31:0] t_wd = '0, t_rd;
    logic        t_inr, t_ov, t_ae;
    logic [7:0]  t_od;

    // receive-mode instance
    logic        r_sel = 0, r_wr = 0, r_addr = 0, r_iv = 0;
    logic [7:0]  r_id = '0;
    logic [31:0] r_wd = '0, r_rd;
    logic        r_inr, r_ov, r_ae;
    logic [7:0]  r_od;

    byte_fifo_csr #(.DEPTH(64), .IS_RX(1'b0)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(t_sel), .bus_wr(t_wr), .bus_addr(t_addr),
        .bus_wdata(t_wd), .bus_rdata(t_rd), .in_valid(1'b0), .in_data(8'h00),
        .in_ready(t_inr), .out_valid(t_ov), .out_data(t_od), .out_ready(t_rdy),
        .almost_empty(t_ae)
    );

    byte_fifo_csr #(.DEPTH(64), .IS_RX(1'b1)) rx_i (
        .clk(clk), .rst(rst), .bus_sel(r_sel), .bus_wr(r_wr), .bus_addr(r_addr),
        .bus_wdata(r_wd), .bus_rdata(r_rd), .in_valid(r_iv), .in_data(r_id),
        .in_ready(r_inr), .out_valid(r_ov), .out_data(r_od), .out_ready(1'b0),
        .almost_empty(r_ae)
    );

    int total = 0;
    int bad   = 0;
    bit over  = 0;

    typedef struct packed {
        logic       take;
        logic [7:0] val;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 8'h11}, '{1'b0, 8'h22}, '{1'b1, 8'h11}, '{1'b0, 8'h33},
        '{1'b1, 8'h22}, '{1'b1, 8'h33}, '{1'b0, 8'hA5}, '{1'b0, 8'h5A},
        '{1'b0, 8'hFF}, '{1'b1, 8'hA5}, '{1'b1, 8'h5A}, '{1'b1, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        t_sel = 0; t_wr = 0; t_addr = 0; t_rdy = 0; t_wd = '0;
        r_sel = 0; r_wr = 0; r_addr = 0; r_iv = 0; r_wd = '0;
    endtask

    task automatic bus_write(input bit rx, input bit a, input logic [31:0] d);
        @(negedge clk);
        if (rx) begin r_sel = 1; r_wr = 1; r_addr = a; r_wd = d; end
        else    begin t_sel = 1; t_wr = 1; t_addr = a; t_wd = d; end
        @(negedge clk);
        clr();
    endtask

    task automatic bus_read(input bit rx, input bit a, output logic [31:0] d);
        @(negedge clk);
        if (rx) begin r_sel = 1; r_wr = 0; r_addr = a; end
        else    begin t_sel = 1; t_wr = 0; t_addr = a; end
        #2;
        d = rx ? r_rd : t_rd;
        @(negedge clk);
        clr();
    endtask

    task automatic tx_take(output logic v, output logic [7:0] d);
        @(negedge clk);
        #2;
        v = t_ov;
        d = t_od;
        t_rdy = 1;
        @(negedge clk);
        clr();
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        r_iv = 1; r_id = d;
        @(negedge clk);
        clr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        v;
        logic [7:0]  d;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        bus_read(0, 0, rd); check("R1 tx csr", rd, 32'h0000_4000);
        bus_read(1, 0, rd); check("R1 rx csr", rd, 32'h0000_4000);
        check("R1 tx out_valid", {31'b0, t_ov}, 0);
        check("R1 tx almost_empty", {31'b0, t_ae}, 1);
        check("R8 rx in_ready", {31'b0, r_inr}, 1);

        // R2: ordering from the vector table, reserved write bits junk
        foreach (VEC[i]) begin
            if (VEC[i].take) begin
                tx_take(v, d);
                check("R2 out_valid", {31'b0, v}, 1);
                check("R2 out_data", {24'b0, d}, {24'b0, VEC[i].val});
            end else begin
                bus_write(0, 1, {24'hABCDEF, VEC[i].val});
            end
        end
        check("R2 drained out_valid", {31'b0, t_ov}, 0);

        // R5: threshold 3
        bus_write(0, 0, 32'h0000_00C0);
        bus_read(0, 0, rd); check("R5 thr readback", rd, 32'h0000_40C0);
        for (int i = 0; i < 3; i++) bus_write(0, 1, i);
        check("R5 ae at threshold", {31'b0, t_ae}, 1);
        bus_write(0, 1, 3);
        check("R5 ae above threshold", {31'b0, t_ae}, 0);
        bus_read(0, 0, rd); check("R3 level 4", rd, 32'h0000_00C4);

        // R3: fill to 64
        for (int i = 4; i < 64; i++) bus_write(0, 1, i);
        bus_read(0, 0, rd); check("R3 full level 0", rd, 32'h0000_20C0);
        check("R5 full not ae", {31'b0, t_ae}, 0);

        // R4: overflow write is dropped
        bus_write(0, 1, 32'h0000_00EE);
        bus_read(0, 0, rd); check("R4 ovf flag", rd, 32'h0000_A0C0);
        begin
            int errs = 0;
            for (int i = 0; i < 64; i++) begin
                tx_take(v, d);
                if (!v || d != 8'(i)) errs++;
            end
            check("R4 contents intact", errs, 0);
        end
        bus_read(0, 0, rd); check("R4 empty after drain", rd, 32'h0000_C0C0);

        // R7: take while empty
        tx_take(v, d);
        check("R7 out_valid low", {31'b0, v}, 0);
        bus_read(0, 0, rd); check("R7 udf flag", rd, 32'h0001_C0C0);

        // R6: flush with threshold 5
        bus_write(0, 1, 8'h01);
        bus_write(0, 1, 8'h02);
        bus_write(0, 0, 32'h0000_1140);
        bus_read(0, 0, rd); check("R6 flushed", rd, 32'h0000_4140);
        check("R6 out_valid after flush", {31'b0, t_ov}, 0);

        // R9: write and take in one cycle
        bus_write(0, 1, 8'h10);
        bus_write(0, 1, 8'h20);
        @(negedge clk);
        t_sel = 1; t_wr = 1; t_addr = 1; t_wd = 32'h30; t_rdy = 1;
        #2;
        check("R9 oldest leaves", {24'b0, t_od}, 32'h10);
        @(negedge clk);
        clr();
        bus_read(0, 0, rd); check("R9 level kept", rd, 32'h0000_0142);

        // R10: tx data-port read
        bus_read(0, 1, rd); check("R10 tx data read", rd, 32'h0);
        bus_read(0, 0, rd); check("R10 tx no removal", rd, 32'h0000_0142);

        // R8: receive path
        rx_push(8'h41);
        rx_push(8'h42);
        bus_read(1, 1, rd); check("R8 first byte", rd, 32'h41);
        bus_read(1, 1, rd); check("R8 second byte", rd, 32'h42);
        bus_read(1, 1, rd); check("R8 empty read", rd, 32'h0);
        bus_read(1, 0, rd); check("R7 rx udf", rd, 32'h0001_4000);
        bus_write(1, 1, 32'h0000_0099);
        bus_read(1, 0, rd); check("R10 rx write ignored", rd, 32'h0001_4000);
        bus_write(1, 0, 32'h0000_1000);
        for (int i = 0; i < 65; i++) rx_push(8'(i + 1));
        bus_read(1, 0, rd); check("R4 rx overflow", rd, 32'h0000_A000);
        bus_read(1, 1, rd); check("R8 rx oldest", rd, 32'h01);

        // R9: flush and push in the same cycle
        @(negedge clk);
        r_sel = 1; r_wr = 1; r_addr = 0; r_wd = 32'h0000_1000; r_iv = 1; r_id = 8'h77;
        @(negedge clk);
        clr();
        bus_read(1, 0, rd); check("R9 flush wins", rd, 32'h0000_4000);

        over = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule